// File: doc/BRIEF.md
# Uniform/Affine Register Tag Tracker

This block sits beside the issue stage of a wide-lane processor and keeps a small classification tag for every architectural vector register. A tag says whether the register holds one value in every lane (uniform), a linear ramp where lane i holds base + i × stride (affine), or anything else (unknown). Two lanes of value storage are enough to rebuild a uniform or an affine vector. That lets a narrow scalar path stand in for the full vector datapath whenever an instruction touches only such registers.

On every issued instruction the block reads the tags of the two source registers. It derives the tag of the result from the operation and writes that tag back to the destination register. It also raises a scalar-path enable whenever every source the operation reads and its result are uniform or affine. The vector register file and lanes can then be clock-gated for that instruction. Register values, the scalar register file and the vector datapath are outside this block.

Top module: `affine_tag_tracker`

## Requirements
- R1: After a synchronous active-low reset every register tag reads unknown. Tag encoding: unknown = 2'b00, uniform = 2'b01, affine = 2'b10. The value 2'b11 never appears on a tag output.
- R2: The thread-index move (op 3'd1) writes affine to its destination. The immediate move (op 3'd2) writes uniform. Neither reads a source.
- R3: Add (op 3'd3) gives uniform when both sources are uniform. It gives affine when both are uniform or affine and at least one is affine. It gives unknown when either source is unknown.
- R4: Multiply (op 3'd4) gives uniform for uniform × uniform and affine for uniform × affine in either order. It gives unknown for affine × affine or when either source is unknown.
- R5: Load (op 3'd5) reads source A as its address and always writes unknown to its destination.
- R6: Store (op 3'd6) and compare (op 3'd7) read both sources and leave every register tag unchanged, including the one named by the destination field.
- R7: A writing operation issued with any lane of `lane_mask` cleared writes unknown to its destination.
- R8: `scalar_en` is high during a valid issue only when every source the operation reads is uniform or affine, and, for a writing operation, the resulting tag is uniform or affine as well. Operations without a result (store, compare) are judged on their sources alone.
- R9: A tag written by an issue is visible on the read ports from the next cycle on. A read of the same register in the same cycle sees the old tag.
- R10: With `issue_valid` low, or with the no-op (op 3'd0), no tag is written and `scalar_en` is low.
- R11: `src_a_tag` and `src_b_tag` always show the stored tags of the registers named by `src_a_reg` and `src_b_reg`, whether or not an issue is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | An instruction issues this cycle |
| issue_op | input | 3 | Operation code (see requirements) |
| dst_reg | input | 5 | Destination register index |
| src_a_reg | input | 5 | First source register index |
| src_b_reg | input | 5 | Second source register index |
| lane_mask | input | 4 | Active lanes of the issuing instruction |
| src_a_tag | output | 2 | Stored tag of the first source |
| src_b_tag | output | 2 | Stored tag of the second source |
| scalar_en | output | 1 | Instruction may run on the scalar path |

## Verification
A corrupted tag entry surfaces on `src_a_tag` or `src_b_tag` as soon as that register is named as a source. That is one cycle after the faulty write, since the read ports are combinational off the table. A wrong propagation rule stays hidden until the destination is read back. The bench therefore reads back every destination after the stimulus table and checks `scalar_en` during each issue. A missed write-enable gating, such as a store or an inactive issue writing the table, only shows when the untouched register is read back, so those registers are re-read explicitly.

// File: rtl/tag_pkg.sv
// Package: shared tag and operation encodings for the tag tracker.
// Assumes two-bit tags and three-bit operation codes as listed below.
package tag_pkg;
    typedef enum logic [1:0] {
        TAG_UNK = 2'b00,
        TAG_UNI = 2'b01,
        TAG_AFF = 2'b10
    } tag_t;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_TID   = 3'd1,
        OP_IMM   = 3'd2,
        OP_ADD   = 3'd3,
        OP_MUL   = 3'd4,
        OP_LOAD  = 3'd5,
        OP_STORE = 3'd6,
        OP_CMP   = 3'd7
    } op_t;

    // Classifies a tag as usable by the scalar path.
    function automatic logic tag_known(input tag_t t);
        return (t == TAG_UNI) || (t == TAG_AFF);
    endfunction
endpackage

// File: rtl/tag_table.sv
// Module: tag_table
// Holds one tag per architectural register. It has two combinational
// read ports and one synchronous write port, with no write-to-read bypass.
// Assumes a synchronous active-low reset that clears every entry to unknown.
module tag_table
    import tag_pkg::*;
#(
    parameter int NREGS = 32,
    localparam int AW = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  tag_t          wr_tag,
    input  logic [AW-1:0] rd_a_addr,
    input  logic [AW-1:0] rd_b_addr,
    output tag_t          rd_a_tag,
    output tag_t          rd_b_tag
);
    tag_t mem [NREGS];

    // Stores the tag on a write, or clears every entry in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                mem[i] <= TAG_UNK;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_tag;
        end
    end

    // Drives both read ports straight from the storage.
    always_comb begin
        rd_a_tag = mem[rd_a_addr];
        rd_b_tag = mem[rd_b_addr];
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (rd_a_tag == TAG_UNK) && (rd_b_tag == TAG_UNK));

    p_legal_tag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_tag != 2'b11) && (rd_b_tag != 2'b11));

    p_write_visible_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(wr_addr)] == $past(wr_tag)));
endmodule

// File: rtl/op_decode.sv
// Module: op_decode
// Turns an operation code into its operand usage: which sources it reads
// and whether it produces a result tag. It is purely combinational.
module op_decode
    import tag_pkg::*;
(
    input  op_t  op,
    output logic use_a,
    output logic use_b,
    output logic writes
);
    // Maps each operation to the sources it reads and whether it writes.
    always_comb begin
        use_a  = 1'b0;
        use_b  = 1'b0;
        writes = 1'b0;
        unique case (op)
            OP_NOP:   ;
            OP_TID,
            OP_IMM:   writes = 1'b1;
            OP_ADD,
            OP_MUL:   begin use_a = 1'b1; use_b = 1'b1; writes = 1'b1; end
            OP_LOAD:  begin use_a = 1'b1; writes = 1'b1; end
            OP_STORE,
            OP_CMP:   begin use_a = 1'b1; use_b = 1'b1; end
            default:  ;
        endcase
    end
endmodule

// File: rtl/tag_propagate.sv
// Module: tag_propagate
// Computes the result tag of an operation from its source tags. A partial
// lane mask forces the result to unknown. It is purely combinational and
// assumes that its caller ignores the output of non-writing operations.
module tag_propagate
    import tag_pkg::*;
(
    input  op_t  op,
    input  tag_t tag_a,
    input  tag_t tag_b,
    input  logic mask_full,
    output tag_t res_tag
);
    tag_t raw;

    // Applies the per-operation classification rules.
    always_comb begin
        raw = TAG_UNK;
        unique case (op)
            OP_TID:  raw = TAG_AFF;
            OP_IMM:  raw = TAG_UNI;
            OP_ADD: begin
                if (!tag_known(tag_a) || !tag_known(tag_b))
                    raw = TAG_UNK;
                else if (tag_a == TAG_UNI && tag_b == TAG_UNI)
                    raw = TAG_UNI;
                else
                    raw = TAG_AFF;
            end
            OP_MUL: begin
                if (tag_a == TAG_UNI && tag_b == TAG_UNI)
                    raw = TAG_UNI;
                else if ((tag_a == TAG_UNI && tag_b == TAG_AFF) ||
                         (tag_a == TAG_AFF && tag_b == TAG_UNI))
                    raw = TAG_AFF;
                else
                    raw = TAG_UNK;
            end
            default: raw = TAG_UNK;
        endcase
    end

    // Forces the result to unknown when some lanes are inactive.
    always_comb begin
        res_tag = mask_full ? raw : TAG_UNK;
    end
endmodule

// File: rtl/affine_tag_tracker.sv
// Module: affine_tag_tracker (top)
// Tracks uniform/affine/unknown tags for the vector registers at issue,
// reports the source tags and raises a scalar-path enable. It assumes one
// instruction per cycle and a synchronous active-low reset.
module affine_tag_tracker
    import tag_pkg::*;
#(
    parameter int NREGS = 32,
    parameter int LANES = 4,
    localparam int AW = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    input  logic [2:0]       issue_op,
    input  logic [AW-1:0]    dst_reg,
    input  logic [AW-1:0]    src_a_reg,
    input  logic [AW-1:0]    src_b_reg,
    input  logic [LANES-1:0] lane_mask,
    output logic [1:0]       src_a_tag,
    output logic [1:0]       src_b_tag,
    output logic             scalar_en
);
    op_t  op;
    tag_t ta, tb, res_tag;
    logic use_a, use_b, writes, mask_full, wr_en, srcs_ok, res_ok;

    // Casts the raw operation code and checks the lane mask.
    always_comb begin
        op        = op_t'(issue_op);
        mask_full = &lane_mask;
    end

    tag_table #(.NREGS(NREGS)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (dst_reg),
        .wr_tag    (res_tag),
        .rd_a_addr (src_a_reg),
        .rd_b_addr (src_b_reg),
        .rd_a_tag  (ta),
        .rd_b_tag  (tb)
    );

    op_decode u_dec (
        .op     (op),
        .use_a  (use_a),
        .use_b  (use_b),
        .writes (writes)
    );

    tag_propagate u_prop (
        .op        (op),
        .tag_a     (ta),
        .tag_b     (tb),
        .mask_full (mask_full),
        .res_tag   (res_tag)
    );

    // Combines operand usage and tags into the write enable and the scalar enable.
    always_comb begin
        wr_en     = issue_valid && writes;
        srcs_ok   = (!use_a || tag_known(ta)) && (!use_b || tag_known(tb));
        res_ok    = !writes || tag_known(res_tag);
        scalar_en = issue_valid && (op != OP_NOP) && srcs_ok && res_ok;
        src_a_tag = ta;
        src_b_tag = tb;
    end

    p_partial_unknown_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mask_full) |-> (res_tag == TAG_UNK));

    p_scalar_sources_r8: assert property (@(posedge clk) disable iff (!rst_n)
        scalar_en |-> ((!use_a || src_a_tag != 2'b00) && (!use_b || src_b_tag != 2'b00)));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue_valid || op == OP_NOP) |-> (!scalar_en && !wr_en));

    p_nowrite_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STORE || op == OP_CMP) |-> !wr_en);

    p_tid_affine_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_TID && mask_full) |-> (res_tag == TAG_AFF));

    p_load_unknown_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && op == OP_LOAD) |-> !scalar_en);
endmodule

// File: tb/tb_affine_tag_tracker.sv
module tb_affine_tag_tracker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue_valid = 1'b0;
    logic [2:0] issue_op = 3'd0;
    logic [4:0] dst_reg = 5'd0, src_a_reg = 5'd0, src_b_reg = 5'd0;
    logic [3:0] lane_mask = 4'hF;
    logic [1:0] src_a_tag, src_b_tag;
    logic       scalar_en;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    affine_tag_tracker dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
        .dst_reg(dst_reg), .src_a_reg(src_a_reg), .src_b_reg(src_b_reg),
        .lane_mask(lane_mask), .src_a_tag(src_a_tag), .src_b_tag(src_b_tag),
        .scalar_en(scalar_en)
    );

    // Vector fields: op(3) dst(5) a(5) b(5) mask(4) exp_a(2) exp_b(2) exp_en(1)
    localparam int NV = 14;
    localparam logic [26:0] VEC [NV] = '{
        {3'd1, 5'd1,  5'd0, 5'd0, 4'hF, 2'd0, 2'd0, 1'b1}, // R2 tid -> r1 aff
        {3'd2, 5'd2,  5'd1, 5'd0, 4'hF, 2'd2, 2'd0, 1'b1}, // R2 R9 imm -> r2 uni
        {3'd3, 5'd3,  5'd1, 5'd2, 4'hF, 2'd2, 2'd1, 1'b1}, // R3 aff+uni
        {3'd3, 5'd4,  5'd2, 5'd2, 4'hF, 2'd1, 2'd1, 1'b1}, // R3 uni+uni
        {3'd4, 5'd5,  5'd3, 5'd4, 4'hF, 2'd2, 2'd1, 1'b1}, // R4 aff*uni
        {3'd4, 5'd6,  5'd5, 5'd3, 4'hF, 2'd2, 2'd2, 1'b0}, // R4 aff*aff
        {3'd4, 5'd7,  5'd4, 5'd0, 4'hF, 2'd1, 2'd0, 1'b0}, // R4 uni*unk
        {3'd3, 5'd8,  5'd1, 5'd7, 4'hF, 2'd2, 2'd0, 1'b0}, // R3 aff+unk
        {3'd5, 5'd9,  5'd3, 5'd0, 4'hF, 2'd2, 2'd0, 1'b0}, // R5 load aff addr
        {3'd6, 5'd10, 5'd3, 5'd4, 4'hF, 2'd2, 2'd1, 1'b1}, // R6 store
        {3'd7, 5'd11, 5'd4, 5'd1, 4'hF, 2'd1, 2'd2, 1'b1}, // R6 cmp
        {3'd3, 5'd12, 5'd4, 5'd4, 4'h7, 2'd1, 2'd1, 1'b0}, // R7 partial add
        {3'd6, 5'd13, 5'd3, 5'd4, 4'h3, 2'd2, 2'd1, 1'b1}, // R8 partial store
        {3'd3, 5'd14, 5'd6, 5'd9, 4'hF, 2'd0, 2'd0, 1'b0}  // R8 unk+unk
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drives one issue at the falling edge and samples the combinational outputs.
    task automatic issue(input logic v, input logic [2:0] op, input logic [4:0] d,
                         input logic [4:0] a, input logic [4:0] b, input logic [3:0] m,
                         output logic [1:0] ta, output logic [1:0] tb, output logic en);
        @(negedge clk);
        issue_valid = v; issue_op = op; dst_reg = d;
        src_a_reg = a; src_b_reg = b; lane_mask = m;
        #1;
        ta = src_a_tag; tb = src_b_tag; en = scalar_en;
    endtask

    // Reads two register tags with no issue in progress.
    task automatic peek(input logic [4:0] a, input logic [4:0] b,
                        input logic [1:0] ea, input logic [1:0] eb, input string req);
        logic [1:0] ta, tb;
        logic en;
        issue(1'b0, 3'd0, 5'd0, a, b, 4'hF, ta, tb, en);
        check(req, {2'b0, ta}, {2'b0, ea});
        check(req, {2'b0, tb}, {2'b0, eb});
    endtask

    initial begin
        logic [1:0] ta, tb;
        logic en;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        peek(5'd0, 5'd31, 2'd0, 2'd0, "R1 reset");
        peek(5'd1, 5'd17, 2'd0, 2'd0, "R1 reset");
        for (int i = 0; i < NV; i++) begin
            logic [26:0] v;
            v = VEC[i];
            issue(1'b1, v[26:24], v[23:19], v[18:14], v[13:9], v[8:5], ta, tb, en);
            check("R11 table src a", {2'b0, ta}, {2'b0, v[4:3]});
            check("R11 table src b", {2'b0, tb}, {2'b0, v[2:1]});
            check("R8 table scalar_en", {3'b0, en}, {3'b0, v[0]});
        end
        peek(5'd1, 5'd2, 2'd2, 2'd1, "R2 readback");
        peek(5'd3, 5'd4, 2'd2, 2'd1, "R3 readback");
        peek(5'd5, 5'd6, 2'd2, 2'd0, "R4 readback");
        peek(5'd7, 5'd8, 2'd0, 2'd0, "R4 R3 unknown readback");
        peek(5'd9, 5'd10, 2'd0, 2'd0, "R5 R6 readback");
        peek(5'd11, 5'd12, 2'd0, 2'd0, "R6 R7 readback");
        peek(5'd13, 5'd14, 2'd0, 2'd0, "R6 R3 readback");
        // R10: inactive issue writes nothing and keeps scalar_en low
        issue(1'b0, 3'd2, 5'd20, 5'd1, 5'd2, 4'hF, ta, tb, en);
        check("R10 invalid scalar_en", {3'b0, en}, 4'd0);
        peek(5'd20, 5'd0, 2'd0, 2'd0, "R10 no write");
        // R10: no-op with valid high
        issue(1'b1, 3'd0, 5'd21, 5'd1, 5'd2, 4'hF, ta, tb, en);
        check("R10 nop scalar_en", {3'b0, en}, 4'd0);
        peek(5'd21, 5'd0, 2'd0, 2'd0, "R10 nop no write");
        // R9: same-cycle read sees old tag, next cycle sees new
        issue(1'b1, 3'd1, 5'd22, 5'd22, 5'd22, 4'hF, ta, tb, en);
        check("R9 same cycle old", {2'b0, ta}, 4'd0);
        issue(1'b1, 3'd2, 5'd1, 5'd22, 5'd1, 4'hF, ta, tb, en);
        check("R9 next cycle new", {2'b0, ta}, 4'd2);
        check("R9 overwrite old", {2'b0, tb}, 4'd2);
        peek(5'd1, 5'd22, 2'd1, 2'd2, "R9 overwrite");
        // R5: load through a uniform address still unknown and not scalar
        issue(1'b1, 3'd5, 5'd23, 5'd2, 5'd0, 4'hF, ta, tb, en);
        check("R5 uni load scalar_en", {3'b0, en}, 4'd0);
        peek(5'd23, 5'd0, 2'd0, 2'd0, "R5 uni load");
        // R7: partial-mask thread-index move gives unknown
        issue(1'b1, 3'd1, 5'd24, 5'd0, 5'd0, 4'hE, ta, tb, en);
        check("R7 partial tid scalar_en", {3'b0, en}, 4'd0);
        peek(5'd24, 5'd0, 2'd0, 2'd0, "R7 partial tid");
        // R4: uniform * affine (swapped order)
        issue(1'b1, 3'd4, 5'd25, 5'd2, 5'd22, 4'hF, ta, tb, en);
        check("R4 uni*aff scalar_en", {3'b0, en}, 4'd1);
        peek(5'd25, 5'd0, 2'd2, 2'd0, "R4 uni*aff");
        // R1: reset mid-run clears tags
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        peek(5'd1, 5'd22, 2'd0, 2'd0, "R1 reset mid-run");
        peek(5'd3, 5'd25, 2'd0, 2'd0, "R1 reset mid-run");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule